// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits at the issue point of an in-order machine that has two execution pipes, a primary pipe and a secondary pipe. Each cycle it looks at the two oldest decoded instructions, the older slot and the younger slot. It decides whether both can leave together, or whether only the older one leaves.

When the two are paired, the older instruction goes to the primary pipe and the younger one goes to the secondary pipe. When pairing fails, the older instruction goes alone to the primary pipe. The younger one then moves into the older slot for the next cycle, where it may pair with whatever follows it.

The decision is combinational, and it produces an advance count that the instruction queue uses in the same cycle. The pipe assignment is captured in an issue register that feeds the two pipes.

Top module: `dual_issue_pair`

## Requirements
- R1: If either slot is flagged complex (needs microcode sequencing), the pair does not dual-issue.
- R2: If the older slot is any jump (unconditional or conditional), the pair does not dual-issue. A jump in the younger slot does not block pairing.
- R3: If the older destination register is non-zero and equals either younger source register, the pair does not dual-issue.
- R4: If both destination registers are equal and non-zero, the pair does not dual-issue.
- R5: An older condition-code writer followed by a younger conditional jump dual-issues when no other rule blocks it. A register dependence between the two still blocks it.
- R6: A younger instruction that needs primary-only resources blocks pairing. An older primary-only instruction does not block pairing.
- R7: Register 0 never creates a dependence, whether it appears as a destination or as a source.
- R8: The advance output is combinational and is valid in the same cycle as its inputs. It is 2 when the pair issues, 1 when only the older instruction issues, and 0 when the older slot is empty or stall is high.
- R9: On the clock edge after a decision, the primary valid is 1 exactly when at least one instruction issued, and it carries the older tag. The secondary valid is 1 exactly when the pair issued, and it carries the younger tag.
- R10: When the younger slot is empty and the older slot is valid with no stall, the older instruction issues alone (advance 1, primary valid 1, secondary valid 0).
- R11: While reset is held and right after it, both pipe valids are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Downstream stall: nothing issues |
| old_vld_i | input | 1 | Older slot holds an instruction |
| old_tag_i | input | TAG_W | Older instruction identifier |
| old_cplx_i | input | 1 | Older instruction is complex |
| old_jmp_i | input | 1 | Older instruction is an unconditional jump |
| old_jcc_i | input | 1 | Older instruction is a conditional jump |
| old_setcc_i | input | 1 | Older instruction writes the condition codes |
| old_ponly_i | input | 1 | Older instruction needs primary-only resources |
| old_dst_i | input | REG_W | Older destination register (0 = none) |
| old_srca_i | input | REG_W | Older first source register |
| old_srcb_i | input | REG_W | Older second source register |
| yng_vld_i | input | 1 | Younger slot holds an instruction |
| yng_tag_i | input | TAG_W | Younger instruction identifier |
| yng_cplx_i | input | 1 | Younger instruction is complex |
| yng_jmp_i | input | 1 | Younger instruction is an unconditional jump |
| yng_jcc_i | input | 1 | Younger instruction is a conditional jump |
| yng_setcc_i | input | 1 | Younger instruction writes the condition codes |
| yng_ponly_i | input | 1 | Younger instruction needs primary-only resources |
| yng_dst_i | input | REG_W | Younger destination register (0 = none) |
| yng_srca_i | input | REG_W | Younger first source register |
| yng_srcb_i | input | REG_W | Younger second source register |
| adv_o | output | 2 | Queue advance count (0, 1 or 2) |
| pp_vld_o | output | 1 | Primary pipe receives an instruction |
| pp_tag_o | output | TAG_W | Tag sent to the primary pipe |
| sp_vld_o | output | 1 | Secondary pipe receives an instruction |
| sp_tag_o | output | TAG_W | Tag sent to the secondary pipe |

## Verification
The advance count depends only on the present inputs, so it is due in the same cycle. The bench drives each vector on a falling edge and reads the advance count 2 ns later, before the next rising edge.

The pipe valids and tags pass through one register. They are due after the next rising edge, so the bench reads them 2 ns after that edge. It applies the following vector only at the falling edge after that read, so every result is compared against the vector that caused it.

Expected values come from a bench function that counts the blocking conditions independently. Random vectors draw registers from a small range so that dependences occur often.

// File: rtl/dual_issue_pkg.sv
`timescale 1ns/1ps
package dual_issue_pkg;

  // Why the current pair did or did not dual-issue (priority order in arbiter)
  typedef enum logic [2:0] {
    PC_PAIRED  = 3'd0,
    PC_ALONE   = 3'd1,
    PC_COMPLEX = 3'd2,
    PC_CONTROL = 3'd3,
    PC_PRIMARY = 3'd4,
    PC_RAW     = 3'd5,
    PC_WAW     = 3'd6,
    PC_IDLE    = 3'd7
  } pair_cause_e;

  localparam int ADV_W = 2;

  function automatic logic [ADV_W-1:0] adv_count(input logic go, input logic pair);
    if (!go)  return ADV_W'(0);
    if (pair) return ADV_W'(2);
    return ADV_W'(1);
  endfunction

endpackage

// File: rtl/di_hazard.sv
`timescale 1ns/1ps
module di_hazard #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] old_dst_i,
  input  logic [REG_W-1:0] yng_dst_i,
  input  logic [REG_W-1:0] yng_srca_i,
  input  logic [REG_W-1:0] yng_srcb_i,
  output logic             raw_o,
  output logic             waw_o
);

  localparam logic [REG_W-1:0] NULL_REG = '0;

  // a live register equal to another: register 0 never matches
  function automatic logic live_match(input logic [REG_W-1:0] w, input logic [REG_W-1:0] r);
    return (w != NULL_REG) && (w == r);
  endfunction

  assign raw_o = live_match(old_dst_i, yng_srca_i) | live_match(old_dst_i, yng_srcb_i);
  assign waw_o = live_match(old_dst_i, yng_dst_i);

  a_r7_null_dst_no_dep: assert property (@(posedge clk) disable iff (!rst_n)
    (old_dst_i == NULL_REG) |-> (!raw_o && !waw_o));

  a_r3_srcb_dep_seen: assert property (@(posedge clk) disable iff (!rst_n)
    ((old_dst_i != NULL_REG) && (old_dst_i == yng_srcb_i)) |-> raw_o);

endmodule

// File: rtl/di_pair_arb.sv
`timescale 1ns/1ps
module di_pair_arb
  import dual_issue_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             old_vld_i,
  input  logic             yng_vld_i,
  input  logic             old_cplx_i,
  input  logic             yng_cplx_i,
  input  logic             old_jmp_i,
  input  logic             old_jcc_i,
  input  logic             old_setcc_i,
  input  logic             old_ponly_i,
  input  logic             yng_jmp_i,
  input  logic             yng_jcc_i,
  input  logic             yng_setcc_i,
  input  logic             yng_ponly_i,
  input  logic             raw_i,
  input  logic             waw_i,
  output logic             go_o,
  output logic             pair_o,
  output pair_cause_e      cause_o,
  output logic [ADV_W-1:0] adv_o
);

  logic old_ctrl;   // older slot redirects fetch
  logic cc_link;    // flag producer followed by flag consumer: no block
  logic no_block;   // independent restatement used by the checks below

  assign old_ctrl = old_jmp_i | old_jcc_i;
  assign cc_link  = old_setcc_i & yng_jcc_i;
  assign no_block = !old_cplx_i && !yng_cplx_i && !old_jmp_i && !old_jcc_i &&
                    !yng_ponly_i && !raw_i && !waw_i;

  always_comb begin
    if (stall_i || !old_vld_i)        cause_o = PC_IDLE;
    else if (!yng_vld_i)              cause_o = PC_ALONE;
    else if (old_cplx_i | yng_cplx_i) cause_o = PC_COMPLEX;
    else if (old_ctrl)                cause_o = PC_CONTROL;
    else if (yng_ponly_i)             cause_o = PC_PRIMARY;
    else if (raw_i)                   cause_o = PC_RAW;
    else if (waw_i)                   cause_o = PC_WAW;
    else                              cause_o = PC_PAIRED;
  end

  assign go_o   = (cause_o != PC_IDLE);
  assign pair_o = (cause_o == PC_PAIRED);
  assign adv_o  = adv_count(go_o, pair_o);

  a_r1_no_complex_pair: assert property (@(posedge clk) disable iff (!rst_n)
    pair_o |-> (!old_cplx_i && !yng_cplx_i));

  a_r2_no_pair_after_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (old_jmp_i || old_jcc_i) |-> !pair_o);

  a_r2_young_jump_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && yng_vld_i && no_block && yng_jmp_i) |-> pair_o);

  a_r5_cc_then_jcc_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && yng_vld_i && no_block && cc_link) |-> pair_o);

  a_r6_young_primary_alone: assert property (@(posedge clk) disable iff (!rst_n)
    yng_ponly_i |-> !pair_o);

  a_r6_old_primary_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && yng_vld_i && no_block && old_ponly_i && !yng_setcc_i) |-> pair_o);

  a_r8_idle_adv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i || !old_vld_i) |-> (adv_o == 2'd0));

  a_r10_alone_when_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && old_vld_i && !yng_vld_i) |-> (adv_o == 2'd1));

endmodule

// File: rtl/di_issue_reg.sv
`timescale 1ns/1ps
module di_issue_reg #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             pair_i,
  input  logic [TAG_W-1:0] old_tag_i,
  input  logic [TAG_W-1:0] yng_tag_i,
  output logic             pp_vld_o,
  output logic [TAG_W-1:0] pp_tag_o,
  output logic             sp_vld_o,
  output logic [TAG_W-1:0] sp_tag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_vld_o <= 1'b0;
      sp_vld_o <= 1'b0;
      pp_tag_o <= '0;
      sp_tag_o <= '0;
    end else begin
      pp_vld_o <= go_i;
      sp_vld_o <= go_i & pair_i;
      pp_tag_o <= go_i ? old_tag_i : '0;
      sp_tag_o <= (go_i & pair_i) ? yng_tag_i : '0;
    end
  end

  a_r9_primary_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (pp_vld_o && pp_tag_o == $past(old_tag_i)));

  a_r9_primary_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |=> !pp_vld_o);

  a_r9_secondary_needs_primary: assert property (@(posedge clk) disable iff (!rst_n)
    sp_vld_o |-> pp_vld_o);

  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!pp_vld_o && !sp_vld_o));

endmodule

// File: rtl/dual_issue_pair.sv
`timescale 1ns/1ps
module dual_issue_pair
  import dual_issue_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             old_vld_i,
  input  logic [TAG_W-1:0] old_tag_i,
  input  logic             old_cplx_i,
  input  logic             old_jmp_i,
  input  logic             old_jcc_i,
  input  logic             old_setcc_i,
  input  logic             old_ponly_i,
  input  logic [REG_W-1:0] old_dst_i,
  input  logic [REG_W-1:0] old_srca_i,
  input  logic [REG_W-1:0] old_srcb_i,
  input  logic             yng_vld_i,
  input  logic [TAG_W-1:0] yng_tag_i,
  input  logic             yng_cplx_i,
  input  logic             yng_jmp_i,
  input  logic             yng_jcc_i,
  input  logic             yng_setcc_i,
  input  logic             yng_ponly_i,
  input  logic [REG_W-1:0] yng_dst_i,
  input  logic [REG_W-1:0] yng_srca_i,
  input  logic [REG_W-1:0] yng_srcb_i,
  output logic [1:0]       adv_o,
  output logic             pp_vld_o,
  output logic [TAG_W-1:0] pp_tag_o,
  output logic             sp_vld_o,
  output logic [TAG_W-1:0] sp_tag_o
);

  logic        raw_hit;
  logic        waw_hit;
  logic        issue_go;
  logic        issue_pair;
  pair_cause_e pair_cause;
  logic [ADV_W-1:0] adv_w;
  logic        old_src_seen;  // older sources only matter to earlier stages

  assign old_src_seen = |{old_srca_i, old_srcb_i};

  di_hazard #(.REG_W(REG_W)) u_hazard (
    .clk        (clk),
    .rst_n      (rst_n),
    .old_dst_i  (old_dst_i),
    .yng_dst_i  (yng_dst_i),
    .yng_srca_i (yng_srca_i),
    .yng_srcb_i (yng_srcb_i),
    .raw_o      (raw_hit),
    .waw_o      (waw_hit)
  );

  di_pair_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (stall_i),
    .old_vld_i   (old_vld_i),
    .yng_vld_i   (yng_vld_i),
    .old_cplx_i  (old_cplx_i),
    .yng_cplx_i  (yng_cplx_i),
    .old_jmp_i   (old_jmp_i),
    .old_jcc_i   (old_jcc_i),
    .old_setcc_i (old_setcc_i),
    .old_ponly_i (old_ponly_i),
    .yng_jmp_i   (yng_jmp_i),
    .yng_jcc_i   (yng_jcc_i),
    .yng_setcc_i (yng_setcc_i),
    .yng_ponly_i (yng_ponly_i),
    .raw_i       (raw_hit),
    .waw_i       (waw_hit),
    .go_o        (issue_go),
    .pair_o      (issue_pair),
    .cause_o     (pair_cause),
    .adv_o       (adv_w)
  );

  di_issue_reg #(.TAG_W(TAG_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (issue_go),
    .pair_i    (issue_pair),
    .old_tag_i (old_tag_i),
    .yng_tag_i (yng_tag_i),
    .pp_vld_o  (pp_vld_o),
    .pp_tag_o  (pp_tag_o),
    .sp_vld_o  (sp_vld_o),
    .sp_tag_o  (sp_tag_o)
  );

  assign adv_o = adv_w;

  a_r8_adv_two_means_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_o == 2'd2) |=> sp_vld_o);

  a_r4_same_dst_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((old_dst_i != '0) && (old_dst_i == yng_dst_i)) |-> (adv_o != 2'd2));

  a_r3_raw_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_cause == PC_RAW) |-> (raw_hit && adv_o == 2'd1));

  a_r7_sources_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (old_src_seen && adv_o == 2'd2) |-> issue_pair);

endmodule

// File: tb/dual_issue_pair_tb.sv
`timescale 1ns/1ps
module dual_issue_pair_tb;

  localparam int REG_W = 5;
  localparam int TAG_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             stall;
  logic             o_vld, o_cplx, o_jmp, o_jcc, o_setcc, o_ponly;
  logic             y_vld, y_cplx, y_jmp, y_jcc, y_setcc, y_ponly;
  logic [TAG_W-1:0] o_tag, y_tag;
  logic [REG_W-1:0] o_dst, o_sa, o_sb, y_dst, y_sa, y_sb;
  logic [1:0]       adv;
  logic             pp_vld, sp_vld;
  logic [TAG_W-1:0] pp_tag, sp_tag;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  int  unsigned seed_val;

  dual_issue_pair #(.REG_W(REG_W), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall),
    .old_vld_i(o_vld), .old_tag_i(o_tag), .old_cplx_i(o_cplx), .old_jmp_i(o_jmp),
    .old_jcc_i(o_jcc), .old_setcc_i(o_setcc), .old_ponly_i(o_ponly),
    .old_dst_i(o_dst), .old_srca_i(o_sa), .old_srcb_i(o_sb),
    .yng_vld_i(y_vld), .yng_tag_i(y_tag), .yng_cplx_i(y_cplx), .yng_jmp_i(y_jmp),
    .yng_jcc_i(y_jcc), .yng_setcc_i(y_setcc), .yng_ponly_i(y_ponly),
    .yng_dst_i(y_dst), .yng_srca_i(y_sa), .yng_srcb_i(y_sb),
    .adv_o(adv), .pp_vld_o(pp_vld), .pp_tag_o(pp_tag), .sp_vld_o(sp_vld), .sp_tag_o(sp_tag)
  );

  function automatic bit m_go();
    return o_vld && !stall;
  endfunction

  // count obstacles rather than priority-encode them
  function automatic bit m_pair();
    int obst = 0;
    if (o_cplx) obst++;
    if (y_cplx) obst++;
    if (o_jmp || o_jcc) obst++;
    if (y_ponly) obst++;
    if (o_dst != 0 && y_sa == o_dst) obst++;
    if (o_dst != 0 && y_sb == o_dst) obst++;
    if (o_dst != 0 && y_dst == o_dst) obst++;
    return m_go() && y_vld && (obst == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_stim();
    stall = 0; o_vld = 1; y_vld = 1;
    o_cplx = 0; o_jmp = 0; o_jcc = 0; o_setcc = 0; o_ponly = 0;
    y_cplx = 0; y_jmp = 0; y_jcc = 0; y_setcc = 0; y_ponly = 0;
    o_dst = 5'd1; o_sa = 5'd2; o_sb = 5'd3;
    y_dst = 5'd4; y_sa = 5'd5; y_sb = 5'd6;
    o_tag = 6'd10; y_tag = 6'd11;
  endtask

  // called at a falling edge with stimulus already set
  task automatic apply(input string req);
    bit go, pr;
    int exp_adv;
    logic [TAG_W-1:0] ot, yt;
    go = m_go(); pr = m_pair(); ot = o_tag; yt = y_tag;
    exp_adv = !go ? 0 : (pr ? 2 : 1);
    #2;
    chk(adv == exp_adv[1:0], {req, " adv (R8)"}, adv, exp_adv);
    @(posedge clk); #2;
    chk(pp_vld == go, {req, " primary valid (R9)"}, pp_vld, go);
    chk(sp_vld == pr, {req, " secondary valid (R9)"}, sp_vld, pr);
    if (go) chk(pp_tag == ot, {req, " primary tag (R9)"}, pp_tag, ot);
    if (pr) chk(sp_tag == yt, {req, " secondary tag (R9)"}, sp_tag, yt);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    seed_val = $urandom(32'd20240611);
    clear_stim();
    o_vld = 0; y_vld = 0;
    repeat (3) @(negedge clk);
    // R11: quiet during reset
    chk(!pp_vld && !sp_vld, "R11 during reset", {pp_vld, sp_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pp_vld && !sp_vld, "R11 after reset", {pp_vld, sp_vld}, 0);

    clear_stim(); apply("R8 clean pair");
    clear_stim(); o_cplx = 1; apply("R1 older complex");
    clear_stim(); y_cplx = 1; apply("R1 younger complex");
    clear_stim(); o_jmp = 1; apply("R2 older jump");
    clear_stim(); o_jcc = 1; apply("R2 older cond jump");
    clear_stim(); y_jmp = 1; apply("R2 younger jump pairs");
    clear_stim(); y_sa = o_dst; apply("R3 raw on src a");
    clear_stim(); y_sb = o_dst; apply("R3 raw on src b");
    clear_stim(); y_dst = o_dst; apply("R4 same dst");
    clear_stim(); o_setcc = 1; y_jcc = 1; apply("R5 cc then jcc pairs");
    clear_stim(); o_setcc = 1; y_jcc = 1; y_sa = o_dst; apply("R5 cc then jcc with raw");
    clear_stim(); y_ponly = 1; apply("R6 younger primary-only");
    clear_stim(); o_ponly = 1; apply("R6 older primary-only pairs");
    clear_stim(); o_dst = 0; y_dst = 0; y_sa = 0; apply("R7 reg0 dst");
    clear_stim(); y_sa = 0; y_sb = 0; o_sa = 0; apply("R7 reg0 sources");
    clear_stim(); stall = 1; apply("R8 stall");
    clear_stim(); o_vld = 0; apply("R8 older empty");
    clear_stim(); y_vld = 0; y_cplx = 1; apply("R10 younger empty");

    for (int i = 0; i < 800; i++) begin
      stall   = ($urandom_range(7) == 0);
      o_vld   = ($urandom_range(7) != 0);
      y_vld   = ($urandom_range(3) != 0);
      o_cplx  = ($urandom_range(7) == 0);
      y_cplx  = ($urandom_range(7) == 0);
      o_jmp   = ($urandom_range(9) == 0);
      o_jcc   = ($urandom_range(9) == 0);
      y_jmp   = ($urandom_range(7) == 0);
      y_jcc   = ($urandom_range(3) == 0);
      o_setcc = $urandom_range(1);
      y_setcc = $urandom_range(1);
      o_ponly = ($urandom_range(5) == 0);
      y_ponly = ($urandom_range(5) == 0);
      o_dst = REG_W'($urandom_range(3)); o_sa = REG_W'($urandom_range(3)); o_sb = REG_W'($urandom_range(3));
      y_dst = REG_W'($urandom_range(3)); y_sa = REG_W'($urandom_range(3)); y_sb = REG_W'($urandom_range(3));
      o_tag = TAG_W'($urandom); y_tag = TAG_W'($urandom);
      apply("R3 R4 R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule